// File: doc/BRIEF.md
# Flash Sector Protection Controller

This block is the control and status front end of a serial NOR flash controller. Software programs a protected region through a command word. The block then checks every erase command and every snooped write address against that region. An operation that lies outside the region is forwarded to a downstream flash engine as a single-cycle strobe. An operation that falls inside the region is dropped, and a sticky interrupt flag is raised in its place. The serial protocol and the flash array live elsewhere.

The protected region has a power-of-two length and sits at either the top or the bottom of the array. It is set by a 4-bit protection level and a bottom-anchor bit. The capacity comes from the low byte of the device ID parameter. Sectors are 64 KiB.

Top module: `fprot_ctrl`

## Requirements
- R1: After reset, every register reads zero. No erase, bulk or write strobe is active, and `irq` is low.
- R2: The register word index works as follows:
  - 0 reads the status word.
  - 1 reads the read-only `SILICON_ID` parameter (default 0x17).
  - 2 reads the read-only `DEVICE_ID` parameter (default 0x201A).
  - 3 is the command word, which always reads 0.
  - 4 is interrupt status.
  - 5 is interrupt mask, bits 1:0, read/write.
  - 6 is a 32-bit read/write chip-select word.
  - Index 7 reads 0.
  - Read data is valid in the same cycle as `reg_rd` and is 0 when `reg_rd` is low.
- R3: The status word places protection level bits 2:0 at bits 4:2, level bit 3 at bit 6, and the bottom-anchor bit at bit 5. All other status bits are 0. A command of code 3 (`reg_wdata[7:0]`) loads the level from `reg_wdata[11:8]` and the anchor from `reg_wdata[12]`. The new value is visible from the next cycle. Level 0 removes all protection.
- R4: For a nonzero level N, the protected length is 64 KiB shifted left by N-1, saturated at a capacity of 2^(`DEVICE_ID[7:0]`-6) bytes (1 MiB, 16 sectors by default). With anchor 0 the region ends at the top of the array. With anchor 1 it starts at address 0.
- R5: A command of code 2 takes its sector from `reg_wdata[8 +: SECT_W]`. If that sector is unprotected, `erase_req` pulses for one cycle in the next cycle, with `erase_sector` set to the sector. If it is protected, there is no pulse and interrupt status bit 0 is set.
- R6: A command of code 1 (bulk erase) is rejected whenever the level is nonzero. A rejection sets interrupt status bit 0 and gives no pulse. Otherwise `bulk_req` pulses for one cycle in the next cycle.
- R7: When `snoop_wr` carries an address outside the region, `wr_req` pulses in the next cycle with `wr_addr` equal to that address. When the address is inside the region, there is no pulse and interrupt status bit 1 is set.
- R8: Writing interrupt status clears each bit written as 1 and leaves bits written as 0 unchanged.
- R9: `irq` is the OR of interrupt status bits 1:0, each ANDed with the matching mask bit. It is combinational from the registers.
- R10: When a clear of an interrupt status bit and a new rejection setting that same bit fall in the same cycle, the bit ends up set.
- R11: An erase or write check made in the same cycle as a level change uses the protection that was in force before the change.
- R12: Command codes other than 1, 2 and 3 have no effect. They produce no strobe, no status change and no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| snoop_wr | input | 1 | A flash write is being presented |
| snoop_addr | input | FA_W (20) | Byte address of the snooped write |
| erase_req | output | 1 | Accepted sector erase strobe |
| erase_sector | output | SECT_W (4) | Sector index for `erase_req` |
| bulk_req | output | 1 | Accepted bulk erase strobe |
| wr_req | output | 1 | Accepted write strobe |
| wr_addr | output | FA_W (20) | Address for `wr_req` |
| irq | output | 1 | Masked interrupt |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a software clear of interrupt status and a rejected write setting the same bit. The bench raises both in one cycle by driving a write-one-to-clear and a snooped write into the protected region together. It then reads interrupt status back and expects the bit to still be set.

The second pair is a protection change and a snooped write. The bench removes protection in the same cycle as a write to a protected address. It expects that write to be rejected, and the next write to the same address to pass.

// File: rtl/fprot_pkg.sv
`timescale 1ns/1ps
package fprot_pkg;

  localparam int SECT_LOG2 = 16;

  typedef enum logic [7:0] {
    OP_BULK = 8'd1,
    OP_SECT = 8'd2,
    OP_PROT = 8'd3
  } op_e;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_SID    = 3'd1,
    RG_DID    = 3'd2,
    RG_OP     = 3'd3,
    RG_ISR    = 3'd4,
    RG_IMR    = 3'd5,
    RG_CSEL   = 3'd6
  } reg_e;

  // Protected length in sectors for a level, saturated at 2**sect_w.
  function automatic int unsigned prot_span(input logic [3:0] lvl,
                                            input int unsigned sect_w);
    int unsigned n;
    n = int'(lvl);
    if (n == 0) return 0;
    if (n - 1 >= sect_w) return 1 << sect_w;
    return 1 << (n - 1);
  endfunction

  // Membership of a sector in a region anchored at the bottom or the top.
  function automatic logic in_region(input int unsigned sect,
                                     input int unsigned span,
                                     input logic bottom,
                                     input int unsigned nsect);
    if (bottom) return sect < span;
    return sect >= nsect - span;
  endfunction

endpackage

// File: rtl/fprot_range.sv
`timescale 1ns/1ps
module fprot_range
  import fprot_pkg::*;
#(
  parameter int SECT_W = 4,
  parameter int NQ     = 2
) (
  input  logic [3:0]             level,
  input  logic                   bottom,
  input  logic [NQ-1:0][SECT_W-1:0] q_sect,
  output logic [NQ-1:0]          q_hit,
  output logic                   any_prot
);
  localparam int unsigned NSECT = 1 << SECT_W;

  logic [31:0] span;
  assign span     = prot_span(level, SECT_W);
  assign any_prot = (level != 4'd0);

  for (genvar g = 0; g < NQ; g++) begin : g_query
    assign q_hit[g] = in_region(32'(q_sect[g]), span, bottom, NSECT);
  end
endmodule

// File: rtl/fprot_irq.sv
`timescale 1ns/1ps
module fprot_irq #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_ev,
  input  logic          clr_we,
  input  logic [NB-1:0] clr_mask,
  input  logic          mask_we,
  input  logic [NB-1:0] mask_d,
  output logic [NB-1:0] isr,
  output logic [NB-1:0] imr,
  output logic          irq
);
  logic [NB-1:0] clr_eff;
  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0;
      imr <= '0;
    end else begin
      isr <= (isr & ~clr_eff) | set_ev;
      if (mask_we) imr <= mask_d;
    end
  end

  assign irq = |(isr & imr);
endmodule

// File: rtl/fprot_ctrl.sv
`timescale 1ns/1ps
module fprot_ctrl
  import fprot_pkg::*;
#(
  parameter logic [31:0] SILICON_ID = 32'h0000_0017,
  parameter logic [31:0] DEVICE_ID  = 32'h0000_201A,
  localparam int CAP_LOG2 = int'(DEVICE_ID[7:0]) - 6,
  localparam int FA_W     = CAP_LOG2,
  localparam int SECT_W   = CAP_LOG2 - SECT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              snoop_wr,
  input  logic [FA_W-1:0]   snoop_addr,
  output logic              erase_req,
  output logic [SECT_W-1:0] erase_sector,
  output logic              bulk_req,
  output logic              wr_req,
  output logic [FA_W-1:0]   wr_addr,
  output logic              irq
);
  localparam int NEV = 2;

  // Protection state
  logic [3:0]  prot_lvl;
  logic        prot_bot;
  logic [31:0] csel_q;
  logic [NEV-1:0] isr_q, imr_q;

  // Decoded events, named for the checker
  logic cmd_we, op_bulk, op_sect, op_prot;
  logic [SECT_W-1:0] cmd_sect, wr_sect;
  logic erase_hit, write_hit, any_prot;
  logic erase_ok, erase_bad, bulk_ok, write_ok, write_bad;

  assign cmd_we  = reg_wr && (reg_addr == RG_OP);
  assign op_bulk = cmd_we && (reg_wdata[7:0] == OP_BULK);
  assign op_sect = cmd_we && (reg_wdata[7:0] == OP_SECT);
  assign op_prot = cmd_we && (reg_wdata[7:0] == OP_PROT);

  assign cmd_sect = reg_wdata[8 +: SECT_W];
  assign wr_sect  = snoop_addr[FA_W-1 -: SECT_W];

  logic [1:0][SECT_W-1:0] q_sect;
  logic [1:0]             q_hit;
  assign q_sect[0] = cmd_sect;
  assign q_sect[1] = wr_sect;

  fprot_range #(.SECT_W(SECT_W), .NQ(2)) range_i (
    .level    (prot_lvl),
    .bottom   (prot_bot),
    .q_sect   (q_sect),
    .q_hit    (q_hit),
    .any_prot (any_prot)
  );

  assign erase_hit = q_hit[0];
  assign write_hit = q_hit[1];

  assign erase_ok  = op_sect && !erase_hit;
  assign bulk_ok   = op_bulk && !any_prot;
  assign erase_bad = (op_sect && erase_hit) || (op_bulk && any_prot);
  assign write_ok  = snoop_wr && !write_hit;
  assign write_bad = snoop_wr && write_hit;

  fprot_irq #(.NB(NEV)) irq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   ({write_bad, erase_bad}),
    .clr_we   (reg_wr && (reg_addr == RG_ISR)),
    .clr_mask (reg_wdata[NEV-1:0]),
    .mask_we  (reg_wr && (reg_addr == RG_IMR)),
    .mask_d   (reg_wdata[NEV-1:0]),
    .isr      (isr_q),
    .imr      (imr_q),
    .irq      (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_lvl     <= '0;
      prot_bot     <= 1'b0;
      csel_q       <= '0;
      erase_req    <= 1'b0;
      erase_sector <= '0;
      bulk_req     <= 1'b0;
      wr_req       <= 1'b0;
      wr_addr      <= '0;
    end else begin
      erase_req <= erase_ok;
      bulk_req  <= bulk_ok;
      wr_req    <= write_ok;
      if (erase_ok) erase_sector <= cmd_sect;
      if (write_ok) wr_addr <= snoop_addr;
      if (op_prot) begin
        prot_lvl <= reg_wdata[11:8];
        prot_bot <= reg_wdata[12];
      end
      if (reg_wr && (reg_addr == RG_CSEL)) csel_q <= reg_wdata;
    end
  end

  logic [31:0] status_w;
  assign status_w = {25'd0, prot_lvl[3], prot_bot, prot_lvl[2:0], 2'b00};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        RG_STATUS: reg_rdata = status_w;
        RG_SID:    reg_rdata = SILICON_ID;
        RG_DID:    reg_rdata = DEVICE_ID;
        RG_ISR:    reg_rdata = 32'(isr_q);
        RG_IMR:    reg_rdata = 32'(imr_q);
        RG_CSEL:   reg_rdata = csel_q;
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fprot_ctrl_chk.sv
`timescale 1ns/1ps
module fprot_ctrl_chk #(
  parameter int FA_W   = 20,
  parameter int SECT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic              snoop_wr,
  input logic [FA_W-1:0]   snoop_addr,
  input logic              erase_req,
  input logic [SECT_W-1:0] erase_sector,
  input logic              bulk_req,
  input logic              wr_req,
  input logic [FA_W-1:0]   wr_addr,
  input logic              irq,
  input logic [1:0]        isr,
  input logic [1:0]        imr,
  input logic [3:0]        level
);
  // R5
  erase_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req |-> ($past(reg_wr && reg_addr == 3'd3 && reg_wdata[7:0] == 8'd2)
                   && erase_sector == $past(reg_wdata[8 +: SECT_W])));

  // R7
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ($past(snoop_wr) && wr_addr == $past(snoop_addr)));

  // R6
  bulk_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && reg_wdata[7:0] == 8'd1 && level != 4'd0)
      |=> (!bulk_req && isr[0]));

  // R3
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == 3'd3 && reg_wdata[7:0] == 8'd3) |=> $stable(level));

  // R7
  isr1_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[1]) |-> $past(snoop_wr));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 2'b00) |-> !irq);
endmodule

bind fprot_ctrl fprot_ctrl_chk #(.FA_W(FA_W), .SECT_W(SECT_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .snoop_wr     (snoop_wr),
  .snoop_addr   (snoop_addr),
  .erase_req    (erase_req),
  .erase_sector (erase_sector),
  .bulk_req     (bulk_req),
  .wr_req       (wr_req),
  .wr_addr      (wr_addr),
  .irq          (irq),
  .isr          (isr_q),
  .imr          (imr_q),
  .level        (prot_lvl)
);

// File: tb/fprot_ctrl_tb_top.sv
`timescale 1ns/1ps
module fprot_ctrl_tb_top;
  localparam logic [31:0] SID = 32'h0000_0017;
  localparam logic [31:0] DID = 32'h0000_201A;
  localparam longint CAP = 64'd1 << 20;
  localparam longint SEC = 64'h10000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [2:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [31:0] reg_wdata, reg_rdata;
  logic        snoop_wr;
  logic [19:0] snoop_addr;
  logic        erase_req, bulk_req, wr_req, irq;
  logic [3:0]  erase_sector;
  logic [19:0] wr_addr;

  fprot_ctrl #(.SILICON_ID(SID), .DEVICE_ID(DID)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .snoop_wr(snoop_wr), .snoop_addr(snoop_addr), .erase_req(erase_req),
    .erase_sector(erase_sector), .bulk_req(bulk_req), .wr_req(wr_req),
    .wr_addr(wr_addr), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  int cur_lvl = 0;
  bit cur_bot = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_prot(input int lvl, input bit bot, input longint a);
    longint len;
    if (lvl == 0) return 0;
    len = SEC << (lvl - 1);
    if (len > CAP) len = CAP;
    if (bot) return a < len;
    return a >= CAP - len;
  endfunction

  function automatic logic [31:0] exp_status(input int lvl, input bit bot);
    logic [31:0] s;
    s = 0;
    if (lvl % 2 == 1)      s = s + 32'h04;
    if ((lvl / 2) % 2 == 1) s = s + 32'h08;
    if ((lvl / 4) % 2 == 1) s = s + 32'h10;
    if (lvl >= 8)          s = s + 32'h40;
    if (bot)               s = s + 32'h20;
    return s;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic protect(input int lvl, input bit bot);
    wr_reg(3'd3, (32'(bot) << 12) | (32'(lvl) << 8) | 32'd3);
    cur_lvl = lvl; cur_bot = bot;
  endtask

  task automatic do_erase(input int s, input bit clr);
    logic [31:0] d;
    bit p;
    p = exp_prot(cur_lvl, cur_bot, longint'(s) * SEC);
    wr_reg(3'd3, (32'(s) << 8) | 32'd2);
    chk(erase_req == !p, "R5 erase_req", erase_req, !p);
    if (!p) chk(erase_sector == 4'(s), "R5 erase_sector", erase_sector, s);
    rd_reg(3'd4, d);
    chk(d[0] == p, "R4 R5 illegal-erase flag", d[0], p);
    if (clr) wr_reg(3'd4, 32'h3);
  endtask

  task automatic do_snoop(input longint a, input bit clr);
    logic [31:0] d;
    bit p;
    p = exp_prot(cur_lvl, cur_bot, a);
    @(negedge clk);
    snoop_wr = 1'b1; snoop_addr = 20'(a);
    @(negedge clk);
    snoop_wr = 1'b0;
    chk(wr_req == !p, "R7 wr_req", wr_req, !p);
    if (!p) chk(wr_addr == 20'(a), "R7 wr_addr", wr_addr, a);
    rd_reg(3'd4, d);
    chk(d[1] == p, "R4 R7 illegal-write flag", d[1], p);
    if (clr) wr_reg(3'd4, 32'h3);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk(irq == 0 && erase_req == 0 && bulk_req == 0 && wr_req == 0, "R1 outputs", irq, 0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(3'(i), d);
      if (i == 1)      chk(d == SID, "R2 silicon id", d, SID);
      else if (i == 2) chk(d == DID, "R2 device id", d, DID);
      else             chk(d == 0, "R1 R2 reset value", d, 0);
    end
    chk(reg_rdata == 0, "R2 idle read data", reg_rdata, 0);
  endtask

  task automatic t_csel;
    logic [31:0] d;
    wr_reg(3'd6, 32'hA5A5_0001);
    rd_reg(3'd6, d);
    chk(d == 32'hA5A5_0001, "R2 chip select", d, 32'hA5A5_0001);
    wr_reg(3'd3, 32'hFFFF_FF02 & 32'h0000_0000);
    rd_reg(3'd3, d);
    chk(d == 0, "R2 command reads zero", d, 0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    protect(5, 0); rd_reg(3'd0, d);
    chk(d == exp_status(5, 0), "R3 status lvl5", d, exp_status(5, 0));
    protect(9, 1); rd_reg(3'd0, d);
    chk(d == exp_status(9, 1), "R3 status lvl9 bottom", d, exp_status(9, 1));
    protect(0, 0); rd_reg(3'd0, d);
    chk(d == 0, "R3 status cleared", d, 0);
  endtask

  task automatic t_erase;
    protect(2, 0); do_erase(13, 1); do_erase(14, 1); do_erase(15, 1); do_erase(0, 1);
    protect(3, 1); do_erase(3, 1); do_erase(4, 1); do_erase(15, 1);
    protect(15, 0); do_erase(0, 1); do_erase(8, 1);
    protect(5, 1); do_erase(15, 1);
    protect(0, 0); do_erase(15, 1); do_erase(0, 1);
  endtask

  task automatic t_bulk;
    logic [31:0] d;
    protect(1, 1);
    wr_reg(3'd3, 32'h1);
    chk(bulk_req == 0, "R6 bulk rejected", bulk_req, 0);
    rd_reg(3'd4, d);
    chk(d[0] == 1, "R6 bulk flag", d[0], 1);
    wr_reg(3'd4, 32'h3);
    protect(0, 0);
    wr_reg(3'd3, 32'h1);
    chk(bulk_req == 1, "R6 bulk accepted", bulk_req, 1);
    rd_reg(3'd4, d);
    chk(d == 0, "R6 no flag", d, 0);
  endtask

  task automatic t_snoop;
    protect(1, 0); do_snoop(64'hEFFFF, 1); do_snoop(64'hF0000, 1); do_snoop(64'hFFFFF, 1);
    protect(4, 1); do_snoop(64'h7FFFF, 1); do_snoop(64'h80000, 1);
    protect(0, 0);
  endtask

  task automatic t_w1c_irq;
    logic [31:0] d;
    protect(1, 0);
    do_erase(15, 0); do_snoop(64'hF0000, 0);
    rd_reg(3'd4, d); chk(d == 3, "R8 both set", d, 3);
    chk(irq == 0, "R9 masked", irq, 0);
    wr_reg(3'd5, 32'h1); chk(irq == 1, "R9 bit0 enabled", irq, 1);
    wr_reg(3'd4, 32'h1);
    rd_reg(3'd4, d); chk(d == 2, "R8 clear bit0 only", d, 2);
    chk(irq == 0, "R9 bit1 masked", irq, 0);
    wr_reg(3'd5, 32'h2); chk(irq == 1, "R9 bit1 enabled", irq, 1);
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, d); chk(d == 0, "R8 clear bit1", d, 0);
    chk(irq == 0, "R9 after clear", irq, 0);
    wr_reg(3'd5, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    protect(1, 0);
    do_snoop(64'hF0000, 0);
    @(negedge clk);
    reg_addr = 3'd4; reg_wdata = 32'h2; reg_wr = 1'b1;
    snoop_wr = 1'b1; snoop_addr = 20'hF1234;
    @(negedge clk);
    reg_wr = 1'b0; snoop_wr = 1'b0;
    rd_reg(3'd4, d);
    chk(d[1] == 1, "R10 set wins over clear", d[1], 1);
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, d);
    chk(d[1] == 0, "R8 plain clear", d[1], 0);
  endtask

  task automatic t_same_prot;
    logic [31:0] d;
    protect(1, 0);
    @(negedge clk);
    reg_addr = 3'd3; reg_wdata = 32'h3; reg_wr = 1'b1;
    snoop_wr = 1'b1; snoop_addr = 20'hF8000;
    @(negedge clk);
    reg_wr = 1'b0; snoop_wr = 1'b0;
    cur_lvl = 0; cur_bot = 0;
    chk(wr_req == 0, "R11 old range applies", wr_req, 0);
    rd_reg(3'd4, d);
    chk(d[1] == 1, "R11 rejected flag", d[1], 1);
    wr_reg(3'd4, 32'h3);
    do_snoop(64'hF8000, 1);
  endtask

  task automatic t_badop;
    logic [31:0] d;
    protect(2, 1);
    wr_reg(3'd3, 32'h0000_1F00);
    chk(erase_req == 0 && bulk_req == 0, "R12 code 0 no strobe", erase_req, 0);
    wr_reg(3'd3, 32'h0000_1F04);
    chk(erase_req == 0 && bulk_req == 0, "R12 code 4 no strobe", erase_req, 0);
    rd_reg(3'd0, d);
    chk(d == exp_status(2, 1), "R12 status unchanged", d, exp_status(2, 1));
    rd_reg(3'd4, d);
    chk(d == 0, "R12 no flag", d, 0);
  endtask

  initial begin
    #1000000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    snoop_wr = 1'b0; snoop_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_csel;
    t_status;
    t_erase;
    t_bulk;
    t_snoop;
    t_w1c_irq;
    t_collide;
    t_same_prot;
    t_badop;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule